// File: doc/BRIEF.md
# Serial Character Transmitter with Break Generation

This block is the transmit half of an asynchronous serial port. A host arms the holding register with a status read and then writes an 8-bit character. In long-character mode the character carries a ninth bit taken from a separate input. At the next frame boundary the block moves the character into a shift register. It then drives the character onto the serial line, least significant bit first, one bit per baud tick. The baud tick is a single-cycle strobe supplied from outside the block. An empty flag and an optional interrupt tell the host when the holding register can take the next character.

When the transmitter is switched on, the block first sends a preamble of ones one frame long. A send-break control makes the block repeat all-zero break frames for as long as it is held. When the control is released, the block finishes the break frame in progress and sends a single mark bit before the next character. Clearing the module enable forces the line high and drops the output-enable.

Top module: `txbrk_serializer`

## Requirements
- R1: After reset, and whenever no frame, preamble or break is being shifted, `txd` is 1.
- R2: While `en` and `tx_en` stay high, `txd` changes only on the clock edge that follows a cycle with `baud_tick` high, so every bit lasts from one tick to the next.
- R3: In short mode (`long_mode`=0) a character goes out as 10 bits in this order: a 0 start bit, `wr_data` bits 0 to 7, then a 1 stop bit.
- R4: In long mode (`long_mode`=1) a character goes out as 11 bits in this order: a 0 start bit, `wr_data` bits 0 to 7, the `wr_b8` bit, then a 1 stop bit.
- R5: When `tx_en` rises while `en` is high, the block sends ones for one full frame length (10 or 11 bit times) before any held character. If the rise coincides with a tick, that tick starts the preamble.
- R6: `empty` is 1 after reset. It goes to 1 on the tick that moves the held character into the shift register. It goes to 0 only when `wr_en` follows an earlier `stat_rd` seen while `empty` was 1. A write without that status read leaves `empty` at 1 and sends nothing.
- R7: `irq` is 1 exactly when `irq_en` is 1 and `empty` is 1.
- R8: While `brk` is 1 at a frame boundary, the block loads a break frame of all zeros, one frame length long, and repeats it frame after frame. A held character stays held and `empty` stays 0.
- R9: After `brk` falls, the break frame in progress completes. Then exactly one 1 bit is sent, and the held character starts on the following tick.
- R10: With `en` low, `txd_oe` is 0 and `txd` is 1 in the same cycle, and the frame in progress is abandoned.
- R11: A character written while the previous one is shifting starts on the tick that ends the previous stop bit, with no idle bit between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Module enable; low releases the serial output |
| tx_en | input | 1 | Transmitter enable; a rising edge starts a preamble |
| long_mode | input | 1 | 1 selects 9-bit characters (11-bit frames) |
| baud_tick | input | 1 | One-cycle strobe per bit time |
| stat_rd | input | 1 | Status read strobe; arms the holding register for a write |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Character bits 0 to 7 |
| wr_b8 | input | 1 | Ninth character bit, used in long mode |
| brk | input | 1 | Send-break control |
| irq_en | input | 1 | Transmit interrupt enable |
| txd | output | 1 | Serial data, idle high |
| txd_oe | output | 1 | Output-enable for the serial pin |
| empty | output | 1 | Holding register can take a new character |
| irq | output | 1 | Transmit interrupt request |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that ticks are a few clock cycles apart. They also assume that `stat_rd` and `wr_en` are one-cycle strobes. The property on tick-aligned output changes assumes that `en` and `tx_en` do not move during the observed window. The stimulus raises a tick every fourth cycle and pulses each host strobe for exactly one cycle. It changes `long_mode` only while the transmitter is off or idle, and toggles the enables only at points where the expected waveform is written out. Breaks are raised and released relative to a known tick, so the expected count of zero bits is exact.

// File: rtl/txbrk_pkg.sv
// Shared definitions for the break-capable serial transmitter.
// Assumes nothing beyond a standard SystemVerilog package scope.
package txbrk_pkg;
    // What the shift register takes at a frame boundary.
    typedef enum logic [2:0] {
        LD_IDLE,
        LD_PRE,
        LD_BREAK,
        LD_MARK,
        LD_CHAR
    } load_kind_e;
endpackage

// File: rtl/tx_holding.sv
// Holding register and empty flag.
// A status read taken while empty arms the register, and the next write
// fills it and clears the flag. A write that was not armed is dropped.
// Assumes stat_rd and wr_en are single-cycle strobes.
module tx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_b8,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_b8,
    output logic              empty
);
    logic armed;

    // Holding contents, empty flag and the read-then-write arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty     <= 1'b1;
            armed     <= 1'b0;
            hold_data <= '0;
            hold_b8   <= 1'b0;
        end else begin
            if (take) begin
                empty <= 1'b1;
            end
            if (wr_en && armed) begin
                hold_data <= wr_data;
                hold_b8   <= wr_b8;
                empty     <= 1'b0;
                armed     <= 1'b0;
            end else if (stat_rd && empty) begin
                armed <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_sequencer.sv
// Decides what the shift register loads at each frame boundary.
// Priority: preamble, then break, then the trailing mark bit after a break,
// then a held character. Anything else leaves the line idle.
// Assumes boundary is high when the shifter is idle or on its last bit.
module tx_sequencer
    import txbrk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       tick,
    input  logic       boundary,
    input  logic       brk,
    input  logic       full,
    output load_kind_e kind,
    output logic       take
);
    logic act_q;
    logic pre_pend;
    logic brk_tail;
    logic pre_req;
    logic fire;

    assign pre_req = pre_pend | (active & ~act_q);
    assign fire    = active & tick & boundary;
    assign take    = (kind == LD_CHAR);

    // Select the load at a boundary by fixed priority.
    always_comb begin
        kind = LD_IDLE;
        if (fire) begin
            if (pre_req)       kind = LD_PRE;
            else if (brk)      kind = LD_BREAK;
            else if (brk_tail) kind = LD_MARK;
            else if (full)     kind = LD_CHAR;
        end
    end

    // Track the enable edge, the pending preamble and the owed mark bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            pre_pend <= 1'b0;
            brk_tail <= 1'b0;
        end else begin
            act_q <= active;
            if (!active) begin
                pre_pend <= 1'b0;
                brk_tail <= 1'b0;
            end else begin
                if (kind == LD_PRE)  pre_pend <= 1'b0;
                else if (!act_q)     pre_pend <= 1'b1;
                if (kind == LD_BREAK)     brk_tail <= 1'b1;
                else if (kind == LD_MARK) brk_tail <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tx_shifter.sv
// Shift register and bit counter.
// Sends bit 0 first and refills ones from the top. On a tick at a boundary
// it loads the word the sequencer picked; on other ticks it shifts.
// Assumes long_mode is changed only while idle.
module tx_shifter
    import txbrk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  load_kind_e        kind,
    input  logic              long_mode,
    input  logic [DATA_W-1:0] data,
    input  logic              b8,
    output logic              serial,
    output logic              boundary
);
    localparam int SH_W  = DATA_W + 3;
    localparam int CNT_W = $clog2(SH_W + 1);
    localparam logic [CNT_W-1:0] FR_LONG  = CNT_W'(SH_W);
    localparam logic [CNT_W-1:0] FR_SHORT = CNT_W'(SH_W - 1);

    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] fr_len;
    logic [SH_W-1:0]  char_word;

    assign fr_len    = long_mode ? FR_LONG : FR_SHORT;
    assign char_word = {1'b1, (long_mode ? b8 : 1'b1), data, 1'b0};
    assign boundary  = (cnt <= CNT_W'(1));
    assign serial    = sh[0];

    // Load, shift or clear the serial word on baud ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            sh  <= '1;
            cnt <= '0;
        end else if (tick) begin
            if (boundary) begin
                case (kind)
                    LD_PRE:   begin sh <= '1;        cnt <= fr_len;     end
                    LD_BREAK: begin sh <= '0;        cnt <= fr_len;     end
                    LD_MARK:  begin sh <= '1;        cnt <= CNT_W'(1);  end
                    LD_CHAR:  begin sh <= char_word; cnt <= fr_len;     end
                    default:  begin sh <= '1;        cnt <= '0;         end
                endcase
            end else begin
                sh  <= {1'b1, sh[SH_W-1:1]};
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/txbrk_serializer.sv
// Top of the break-capable serial transmitter.
// Joins the holding register, the load sequencer and the shifter, gates the
// line with the module enable and forms the interrupt.
// Assumes baud_tick is a one-cycle strobe from an external rate generator.
module txbrk_serializer
    import txbrk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tx_en,
    input  logic              long_mode,
    input  logic              baud_tick,
    input  logic              stat_rd,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_b8,
    input  logic              brk,
    input  logic              irq_en,
    output logic              txd,
    output logic              txd_oe,
    output logic              empty,
    output logic              irq
);
    logic              active;
    logic              boundary;
    logic              take;
    logic              serial;
    logic [DATA_W-1:0] hold_data;
    logic              hold_b8;
    load_kind_e        kind;

    assign active = en & tx_en;
    assign txd    = en ? serial : 1'b1;
    assign txd_oe = en;
    assign irq    = irq_en & empty;

    tx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_rd   (stat_rd),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_b8     (wr_b8),
        .take      (take),
        .hold_data (hold_data),
        .hold_b8   (hold_b8),
        .empty     (empty)
    );

    tx_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (baud_tick),
        .boundary (boundary),
        .brk      (brk),
        .full     (~empty),
        .kind     (kind),
        .take     (take)
    );

    tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tick      (baud_tick),
        .kind      (kind),
        .long_mode (long_mode),
        .data      (hold_data),
        .b8        (hold_b8),
        .serial    (serial),
        .boundary  (boundary)
    );
endmodule

// File: rtl/txbrk_serializer_chk.sv
// Protocol checker for the serial transmitter, bound to the top module.
// Assumes single-cycle ticks and host strobes.
module txbrk_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic tx_en,
    input logic baud_tick,
    input logic wr_en,
    input logic brk,
    input logic txd,
    input logic txd_oe,
    input logic empty,
    input logic irq
);
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_oe |-> txd); // R10

    AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(txd) && en && tx_en && $past(en) && $past(tx_en)) |-> $past(baud_tick)); // R2

    AST_EMPTY_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty) |-> $past(baud_tick)); // R6

    AST_EMPTY_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty) |-> $past(wr_en)); // R6

    AST_NO_IRQ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |-> !irq); // R7

    AST_HELD_DURING_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(brk) && ($past(empty) == 1'b0)) |-> !empty); // R8
endmodule

bind txbrk_serializer txbrk_serializer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tx_en     (tx_en),
    .baud_tick (baud_tick),
    .wr_en     (wr_en),
    .brk       (brk),
    .txd       (txd),
    .txd_oe    (txd_oe),
    .empty     (empty),
    .irq       (irq)
);

// File: tb/tb_txbrk_serializer.sv
`timescale 1ns/1ps
module tb_txbrk_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       tx_en = 1'b0;
    logic       long_mode = 1'b0;
    logic       baud_tick = 1'b0;
    logic       stat_rd = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_b8 = 1'b0;
    logic       brk = 1'b0;
    logic       irq_en = 1'b0;
    logic       txd, txd_oe, empty, irq;

    int  n_chk = 0;
    int  n_bad = 0;
    int  tc = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    txbrk_serializer dut (
        .clk(clk), .rst_n(rst_n), .en(en), .tx_en(tx_en), .long_mode(long_mode),
        .baud_tick(baud_tick), .stat_rd(stat_rd), .wr_en(wr_en), .wr_data(wr_data),
        .wr_b8(wr_b8), .brk(brk), .irq_en(irq_en), .txd(txd), .txd_oe(txd_oe),
        .empty(empty), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Baud tick every fourth cycle, driven on the falling edge.
    initial begin
        wait (rst_n);
        forever begin
            @(negedge clk);
            baud_tick = (tc == 3);
            tc = (tc + 1) % 4;
        end
    end

    // Capture the line just before a ticking edge.
    task automatic cap(output bit b, output bit e);
        do begin
            @(negedge clk);
            #1;
        end while (!baud_tick);
        b = txd;
        e = empty;
    endtask

    function automatic logic [10:0] build(input logic [7:0] d, input logic b8, input logic lng);
        return {1'b1, (lng ? b8 : 1'b1), d, 1'b0};
    endfunction

    task automatic host_write(input logic [7:0] d, input logic b8);
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) begin stat_rd = 1'b0; wr_en = 1'b1; wr_data = d; wr_b8 = b8; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic rx_frame(input int exp_ones, input logic [7:0] d, input logic b8,
                            input string req, input bit chk_e);
        bit b, e;
        bit e_prev = 1'b1;
        int ones = 0;
        int fl = long_mode ? 11 : 10;
        logic [10:0] expv = build(d, b8, long_mode);
        logic [10:0] got = '1;
        cap(b, e);
        while (b && ones < 400) begin
            ones++;
            e_prev = e;
            cap(b, e);
        end
        got[0] = b;
        check(ones < 400, req, "start bit seen", ones, 0);
        if (exp_ones >= 0) check(ones == exp_ones, req, "ones before start", ones, exp_ones);
        if (chk_e) begin
            check(e_prev == 1'b0, "R6", "empty before transfer", e_prev, 0);
            check(e == 1'b1, "R6", "empty after transfer", e, 1);
        end
        for (int i = 1; i < fl; i++) begin
            cap(b, e);
            got[i] = b;
        end
        check(got == expv, req, "frame bits", got, expv);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        check(txd == 1'b1, "R1", "txd after reset", txd, 1);
        check(empty == 1'b1, "R6", "empty after reset", empty, 1);
        check(irq == 1'b0, "R7", "irq after reset", irq, 0);
        check(txd_oe == 1'b1, "R10", "oe with en high", txd_oe, 1);
    endtask

    task automatic t_preamble_short();
        bit b, e;
        irq_en = 1'b1; #1;
        check(irq == 1'b1, "R7", "irq when empty", irq, 1);
        host_write(8'hA5, 1'b0); #1;
        check(empty == 1'b0, "R6", "empty after armed write", empty, 0);
        check(irq == 1'b0, "R7", "irq when full", irq, 0);
        cap(b, e);
        tx_en = 1'b1;
        rx_frame(10, 8'hA5, 1'b0, "R5 R3", 1'b1);
        check(irq == 1'b1, "R7", "irq after transfer", irq, 1);
    endtask

    task automatic t_ignored_write();
        bit b, e;
        int zeros = 0;
        @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h00; end
        @(negedge clk) wr_en = 1'b0;
        #1;
        check(empty == 1'b1, "R6", "empty after unarmed write", empty, 1);
        for (int i = 0; i < 25; i++) begin
            cap(b, e);
            if (!b) zeros++;
        end
        check(zeros == 0, "R6", "zero bits after unarmed write", zeros, 0);
    endtask

    task automatic t_back_to_back();
        fork
            begin
                host_write(8'h3C, 1'b0);
                wait (empty == 1'b1);
                host_write(8'hC3, 1'b0);
            end
            begin
                rx_frame(-1, 8'h3C, 1'b0, "R3", 1'b0);
                rx_frame(0, 8'hC3, 1'b0, "R11", 1'b0);
            end
        join
    endtask

    task automatic t_long();
        bit b, e;
        cap(b, e);
        tx_en = 1'b0;
        long_mode = 1'b1;
        host_write(8'h5A, 1'b1);
        cap(b, e);
        tx_en = 1'b1;
        rx_frame(11, 8'h5A, 1'b1, "R4 R5", 1'b0);
        fork
            host_write(8'hFF, 1'b0);
            rx_frame(-1, 8'hFF, 1'b0, "R4", 1'b0);
        join
        cap(b, e);
        long_mode = 1'b0;
    endtask

    task automatic t_break();
        bit b, e;
        cap(b, e);
        brk = 1'b1;
        fork
            begin
                int seen = 0;
                host_write(8'h81, 1'b0);
                while (seen < 24) begin
                    @(negedge clk); #1;
                    if (baud_tick) seen++;
                end
                check(empty == 1'b0, "R8", "char held during break", empty, 0);
                brk = 1'b0;
            end
            begin
                int z = 0;
                int ones = 0;
                bit bb, ee;
                cap(bb, ee);
                while (!bb && z < 400) begin z++; cap(bb, ee); end
                check(z == 30, "R8", "break zero bits", z, 30);
                while (bb && ones < 400) begin ones++; cap(bb, ee); end
                check(ones == 1, "R9", "mark bits after break", ones, 1);
                begin
                    logic [10:0] got = '1;
                    logic [10:0] expv = build(8'h81, 1'b0, 1'b0);
                    got[0] = bb;
                    for (int i = 1; i < 10; i++) begin cap(bb, ee); got[i] = bb; end
                    check(got == expv, "R9", "char after break", got, expv);
                end
            end
        join
    endtask

    task automatic t_irq_off();
        irq_en = 1'b0; #1;
        check(irq == 1'b0, "R7", "irq disabled while empty", irq, 0);
    endtask

    task automatic t_disable();
        bit b, e;
        host_write(8'h00, 1'b0);
        wait (empty == 1'b1);
        @(negedge clk); #1;
        check(txd == 1'b0, "R3", "start bit on line", txd, 0);
        en = 1'b0; #1;
        check(txd_oe == 1'b0, "R10", "oe with en low", txd_oe, 0);
        check(txd == 1'b1, "R10", "txd with en low", txd, 1);
        cap(b, e);
        cap(b, e);
        check(b == 1'b1, "R10", "txd stays high while off", b, 1);
        en = 1'b1;
        cap(b, e);
        check(b == 1'b1, "R1", "line high after re-enable", b, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_preamble_short();
        t_ignored_write();
        t_back_to_back();
        t_long();
        t_break();
        t_irq_off();
        t_disable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run incomplete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule